// File: doc/BRIEF.md
# Deserialized-Sample Pulse Timestamper

This block sits behind a high-speed deserializer that samples a detector discriminator line. Each parallel word carries sixteen samples taken 400 ps apart. The most significant bit is the earliest sample. One word arrives per 6.4 ns word-clock period. For each pulse on the line, the block measures the arrival time and the width. It then emits one record per pulse.

The arrival time combines two parts. The coarse part is a free-running count of accepted words. The fine part is the sample position of the rising edge inside its word. Together they give a timestamp in 400 ps units, equal to `coarse * WORD_W + offset`. The width is the number of consecutive high samples, also in 400 ps units, and it is counted across any number of word boundaries. Only one pulse per word is measured. If a word holds further rising edges, they are dropped and a sticky flag is raised. A counter-clear input restarts the timebase.

Top module: `sample_tdc`

## Requirements
- R1: The low `$clog2(WORD_W)` bits of `rec_time` equal the position of the pulse's first high sample within its word. Position 0 is `word_in[WORD_W-1]`, the earliest sample.
- R2: The upper bits of `rec_time` equal the number of words accepted with `word_vld` high since the last reset or clear. The count is taken before the word that holds the rising edge. Cycles with `word_vld` low neither advance this count nor affect pulse tracking.
- R3: `rec_width` equals the number of consecutive high samples in the pulse, counted across word boundaries. It is always at least 1.
- R4: `rec_valid` is high for exactly one cycle, in the cycle after the clock edge that accepts the word holding the first low sample after the run. A run that ends on a word's last sample is therefore closed by the next accepted word whose first sample is low.
- R5: A run longer than `2**WID_W-1` samples reports `rec_width = 2**WID_W-1` with `rec_sat = 1`. Any shorter run, including one of exactly that length, reports `rec_sat = 0`.
- R6: A rising edge is a low-to-high change in sample order. The previous word's last sample counts as the sample before bit `WORD_W-1`, and it is taken as low after reset or clear. In each word, only one item is measured. If a run is continuing from the previous word, that run is the measured item. Otherwise the measured item is the earliest rising edge in the word. Any other rising edge in the word, together with its continuation into later words, produces no record and sets `multi_hit`.
- R7: `multi_hit` stays high until reset or clear.
- R8: `cnt_clr` sets the word count to 0, discards any open pulse without a record, and clears `multi_hit`. The word presented in the same cycle as `cnt_clr` is ignored.
- R9: While `rst` is high and after it falls, `rec_valid`, `rec_sat` and `multi_hit` are 0.
- R10: The word count wraps modulo `2**CNT_W`, so the timestamp wraps modulo `2**CNT_W * WORD_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_clr | input | 1 | Restarts the word count and drops open pulse state |
| word_vld | input | 1 | Marks `word_in` as a new sample word |
| word_in | input | WORD_W | Sample word, MSB earliest |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_time | output | CNT_W+$clog2(WORD_W) | Arrival timestamp in sample units |
| rec_width | output | WID_W | Pulse width in sample units |
| rec_sat | output | 1 | Width saturated |
| multi_hit | output | 1 | Sticky: an extra edge in a word was dropped |

## Verification
The bound checker checks several properties on every cycle:
- a saturated record always carries the maximum width;
- no record is ever zero wide;
- a record appears only after an accepted word that was not cleared;
- the word count steps by exactly one per accepted word and holds otherwise;
- `multi_hit` stays set until a clear;
- a clear forces a zero count and no record or flag in the next cycle.

Whether the timestamp, the width and the choice of measured edge are correct needs the bench's sample-by-sample reference model. The bench drives every possible word, interleaved with a scrambled companion word, so that runs cross boundaries in many ways. The bench's directed scenarios show saturation at the exact limit, the one-cycle record timing, discarding on clear, and the count wrapping.

// File: rtl/sample_tdc_pkg.sv
package sample_tdc_pkg;
  // Pulse tracking state carried from one word to the next.
  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,  // last sample low
    TRK_RUN  = 2'd1,  // measured run still open
    TRK_SKIP = 2'd2   // ignored run still open
  } trk_state_e;
endpackage

// File: rtl/sample_tdc_scan.sv
// Combinational word analysis: edge location, run length, extra edges.
module sample_tdc_scan #(
  parameter  int WORD_W = 16,
  localparam int OFF_W  = $clog2(WORD_W),
  localparam int LEN_W  = $clog2(WORD_W + 1)
) (
  input  logic [WORD_W-1:0] word,
  input  logic              prev_one,
  input  logic              in_run,
  output logic              edge_found,
  output logic [OFF_W-1:0]  off,
  output logic [LEN_W-1:0]  run_len,
  output logic              run_open,
  output logic              extra_edge
);
  logic [WORD_W-1:0] rise;
  logic [WORD_W-1:0] shifted;
  logic [OFF_W-1:0]  pos;
  logic [LEN_W-1:0]  rise_cnt;
  logic              found;
  logic              going;

  // bit i rises when its predecessor in time (bit i+1, or the previous word) is low
  assign rise = word & ~{prev_one, word[WORD_W-1:1]};

  always_comb begin
    found    = 1'b0;
    pos      = '0;
    rise_cnt = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (rise[i]) begin
        found    = 1'b1;
        pos      = OFF_W'(i);  // last hit = highest index = earliest sample
        rise_cnt = rise_cnt + LEN_W'(1);
      end
    end
  end

  assign off     = in_run ? '0 : (OFF_W'(WORD_W - 1) - pos);
  assign shifted = word << off;

  // count of ones from the MSB of the aligned word
  always_comb begin
    going   = 1'b1;
    run_len = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      going = going & shifted[i];
      if (going) run_len = run_len + LEN_W'(1);
    end
  end

  assign run_open   = ((LEN_W + 1)'(run_len) + (LEN_W + 1)'(off)) == (LEN_W + 1)'(WORD_W);
  assign edge_found = !in_run && found;
  assign extra_edge = in_run ? (rise_cnt != '0) : (rise_cnt > LEN_W'(1));
endmodule

// File: rtl/sample_tdc_coarse.sv
// Accepted-word counter, wraps modulo 2**CNT_W.
module sample_tdc_coarse #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (adv)   count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/sample_tdc_track.sv
// Cross-word pulse state, width accumulation and registered record output.
module sample_tdc_track
  import sample_tdc_pkg::*;
#(
  parameter  int WORD_W = 16,
  parameter  int CNT_W  = 12,
  parameter  int WID_W  = 8,
  localparam int OFF_W  = $clog2(WORD_W),
  localparam int LEN_W  = $clog2(WORD_W + 1),
  localparam int TS_W   = CNT_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             word_vld,
  input  logic             word_last,
  input  logic [CNT_W-1:0] coarse,
  input  logic             edge_found,
  input  logic [OFF_W-1:0] off,
  input  logic [LEN_W-1:0] run_len,
  input  logic             run_open,
  input  logic             extra_edge,
  output logic             prev_one,
  output logic             in_run,
  output logic             rec_valid,
  output logic [TS_W-1:0]  rec_time,
  output logic [WID_W-1:0] rec_width,
  output logic             rec_sat,
  output logic             multi_hit
);
  localparam logic [WID_W-1:0] WMAX = {WID_W{1'b1}};

  trk_state_e       state;
  trk_state_e       rest_state;
  logic [WID_W-1:0] acc;
  logic             acc_sat;
  logic [TS_W-1:0]  start_ts;
  logic [WID_W:0]   sum;
  logic             sum_ovf;
  logic [WID_W-1:0] sum_sat;
  logic [WID_W-1:0] len_ext;

  assign prev_one   = (state != TRK_IDLE);
  assign in_run     = (state == TRK_RUN);
  assign rest_state = word_last ? TRK_SKIP : TRK_IDLE;
  assign len_ext    = WID_W'(run_len);
  assign sum        = (WID_W + 1)'(acc) + (WID_W + 1)'(run_len);
  assign sum_ovf    = sum > (WID_W + 1)'(WMAX);
  assign sum_sat    = sum_ovf ? WMAX : sum[WID_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= TRK_IDLE;
      acc       <= '0;
      acc_sat   <= 1'b0;
      start_ts  <= '0;
      rec_valid <= 1'b0;
      rec_time  <= '0;
      rec_width <= '0;
      rec_sat   <= 1'b0;
      multi_hit <= 1'b0;
    end else begin
      rec_valid <= 1'b0;
      if (clr) begin
        state     <= TRK_IDLE;
        acc       <= '0;
        acc_sat   <= 1'b0;
        multi_hit <= 1'b0;
      end else if (word_vld) begin
        if (extra_edge) multi_hit <= 1'b1;
        if (state == TRK_RUN) begin
          if (run_open) begin
            acc     <= sum_sat;
            acc_sat <= acc_sat | sum_ovf;
          end else begin
            rec_valid <= 1'b1;
            rec_time  <= start_ts;
            rec_width <= sum_sat;
            rec_sat   <= acc_sat | sum_ovf;
            state     <= rest_state;
          end
        end else if (edge_found) begin
          if (run_open) begin
            start_ts <= {coarse, off};
            acc      <= len_ext;
            acc_sat  <= 1'b0;
            state    <= TRK_RUN;
          end else begin
            rec_valid <= 1'b1;
            rec_time  <= {coarse, off};
            rec_width <= len_ext;
            rec_sat   <= 1'b0;
            state     <= rest_state;
          end
        end else begin
          state <= rest_state;
        end
      end
    end
  end
endmodule

// File: rtl/sample_tdc.sv
// Top: deserialized-sample pulse timestamper.
module sample_tdc #(
  parameter  int WORD_W = 16,
  parameter  int CNT_W  = 12,
  parameter  int WID_W  = 8,
  localparam int OFF_W  = $clog2(WORD_W),
  localparam int LEN_W  = $clog2(WORD_W + 1),
  localparam int TS_W   = CNT_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_clr,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_in,
  output logic              rec_valid,
  output logic [TS_W-1:0]   rec_time,
  output logic [WID_W-1:0]  rec_width,
  output logic              rec_sat,
  output logic              multi_hit
);
  logic [CNT_W-1:0] coarse;
  logic             prev_one;
  logic             in_run;
  logic             edge_found;
  logic [OFF_W-1:0] off;
  logic [LEN_W-1:0] run_len;
  logic             run_open;
  logic             extra_edge;

  sample_tdc_coarse #(.CNT_W(CNT_W)) u_coarse (
    .clk   (clk),
    .rst   (rst),
    .clr   (cnt_clr),
    .adv   (word_vld),
    .count (coarse)
  );

  sample_tdc_scan #(.WORD_W(WORD_W)) u_scan (
    .word       (word_in),
    .prev_one   (prev_one),
    .in_run     (in_run),
    .edge_found (edge_found),
    .off        (off),
    .run_len    (run_len),
    .run_open   (run_open),
    .extra_edge (extra_edge)
  );

  sample_tdc_track #(.WORD_W(WORD_W), .CNT_W(CNT_W), .WID_W(WID_W)) u_track (
    .clk        (clk),
    .rst        (rst),
    .clr        (cnt_clr),
    .word_vld   (word_vld),
    .word_last  (word_in[0]),
    .coarse     (coarse),
    .edge_found (edge_found),
    .off        (off),
    .run_len    (run_len),
    .run_open   (run_open),
    .extra_edge (extra_edge),
    .prev_one   (prev_one),
    .in_run     (in_run),
    .rec_valid  (rec_valid),
    .rec_time   (rec_time),
    .rec_width  (rec_width),
    .rec_sat    (rec_sat),
    .multi_hit  (multi_hit)
  );
endmodule

// File: rtl/sample_tdc_chk.sv
// Property checker, bound into every sample_tdc instance.
module sample_tdc_chk #(
  parameter int CNT_W = 12,
  parameter int WID_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_clr,
  input logic             word_vld,
  input logic             rec_valid,
  input logic [WID_W-1:0] rec_width,
  input logic             rec_sat,
  input logic             multi_hit,
  input logic [CNT_W-1:0] coarse
);
  assert_sat_full_R5: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rec_sat |-> rec_width == {WID_W{1'b1}});

  assert_width_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> rec_width != '0);

  assert_rec_after_word_R4: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> $past(word_vld) && !$past(cnt_clr));

  assert_hit_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    $past(multi_hit) && !$past(cnt_clr) |-> multi_hit);

  assert_clear_effect_R8: assert property (@(posedge clk) disable iff (rst)
    $past(cnt_clr) |-> coarse == '0 && !rec_valid && !multi_hit);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(cnt_clr) && $past(word_vld) |-> coarse == CNT_W'($past(coarse) + CNT_W'(1)));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(cnt_clr) && !$past(word_vld) |-> $stable(coarse));
endmodule

bind sample_tdc sample_tdc_chk #(.CNT_W(CNT_W), .WID_W(WID_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_clr   (cnt_clr),
  .word_vld  (word_vld),
  .rec_valid (rec_valid),
  .rec_width (rec_width),
  .rec_sat   (rec_sat),
  .multi_hit (multi_hit),
  .coarse    (coarse)
);

// File: tb/sim_sample_tdc.sv
module sim_sample_tdc;
  localparam int W    = 16;
  localparam int CNT  = 6;
  localparam int WID  = 8;
  localparam int MAXW = 255;
  localparam int TSW  = CNT + 4;
  localparam int QN   = 256;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cnt_clr = 1'b0;
  logic           word_vld = 1'b0;
  logic [W-1:0]   word_in = '0;
  logic           rec_valid;
  logic [TSW-1:0] rec_time;
  logic [WID-1:0] rec_width;
  logic           rec_sat;
  logic           multi_hit;

  sample_tdc #(.WORD_W(W), .CNT_W(CNT), .WID_W(WID)) u0 (
    .clk(clk), .rst(rst), .cnt_clr(cnt_clr), .word_vld(word_vld), .word_in(word_in),
    .rec_valid(rec_valid), .rec_time(rec_time), .rec_width(rec_width),
    .rec_sat(rec_sat), .multi_hit(multi_hit)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state (sample-serial)
  int q_time [QN];
  int q_wid  [QN];
  int q_sat  [QN];
  int q_head = 0;
  int q_tail = 0;
  int m_coarse = 0;
  int m_state = 0;   // 0 idle, 1 measuring, 2 ignoring
  int m_ts = 0;
  int m_wid = 0;
  int m_sat = 0;
  int m_ovf = 0;
  bit m_prev = 0;
  int last_time = -1;
  int n_recs = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_word(input logic [W-1:0] w);
    bit evt = (m_state == 1);
    for (int j = 0; j < W; j++) begin
      bit b = w[W-1-j];
      if (b && !m_prev) begin
        if (!evt) begin
          evt = 1; m_state = 1; m_ts = (m_coarse * W + j) % (1 << TSW); m_wid = 1; m_sat = 0;
        end else begin
          m_state = 2; m_ovf = 1;
        end
      end else if (b && m_prev) begin
        if (m_state == 1) begin
          if (m_wid == MAXW) m_sat = 1; else m_wid++;
        end
      end else if (!b && m_prev) begin
        if (m_state == 1) begin
          q_time[q_tail % QN] = m_ts; q_wid[q_tail % QN] = m_wid; q_sat[q_tail % QN] = m_sat;
          q_tail++;
        end
        m_state = 0;
      end
      m_prev = b;
    end
    m_coarse = (m_coarse + 1) % (1 << CNT);
  endtask

  task automatic send(input logic [W-1:0] w);
    @(negedge clk);
    cnt_clr = 0; word_vld = 1; word_in = w;
    model_word(w);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt_clr = 0; word_vld = 0; word_in = 16'hFFFF;
    end
  endtask

  task automatic do_clr(input logic [W-1:0] w);
    @(negedge clk);
    cnt_clr = 1; word_vld = 1; word_in = w;
    m_coarse = 0; m_state = 0; m_prev = 0; m_ovf = 0;
  endtask

  // record monitor: every strobe is compared with the model queue (R1 R2 R3 R5)
  always @(negedge clk) begin
    if (!rst && !done && rec_valid) begin
      n_recs++;
      last_time = int'(rec_time);
      if (q_head == q_tail) begin
        chk(0, "R4 unexpected record", rec_time, -1);
      end else begin
        chk(rec_time == TSW'(q_time[q_head % QN]), "R1/R2 timestamp", rec_time, q_time[q_head % QN]);
        chk(rec_width == WID'(q_wid[q_head % QN]), "R3 width", rec_width, q_wid[q_head % QN]);
        chk(rec_sat == q_sat[q_head % QN][0], "R5 sat flag", rec_sat, q_sat[q_head % QN]);
        q_head++;
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk(!rec_valid && !rec_sat && !multi_hit, "R9 outputs in reset", {rec_valid, rec_sat, multi_hit}, 0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk(!rec_valid && !multi_hit, "R9 outputs after reset", {rec_valid, multi_hit}, 0);

    // R3 R1: runs crossing a boundary at several fine offsets
    send(16'hFFFF); send(16'hF800); send(16'h0000);
    send(16'h7FFF); send(16'hFC00); send(16'h0000);
    send(16'h0FFF); send(16'hFF80); send(16'h0000);
    send(16'h0001); send(16'hFFFF); send(16'hF000); send(16'h0000);
    // single-word pulses, and R4 boundary-ending run closed by the next word
    send(16'h0FFE); send(16'h0E00); send(16'h0800); send(16'h0001); send(16'h0000);

    // R4: record appears exactly one cycle after the closing word
    gap(2);
    send(16'h0E00);
    @(negedge clk); word_vld = 0;
    chk(rec_valid == 1'b1, "R4 strobe after closing word", rec_valid, 1);
    @(negedge clk);
    chk(rec_valid == 1'b0, "R4 strobe one cycle only", rec_valid, 0);

    // R2: invalid cycles inside a pulse neither count nor break the run
    send(16'h00FF); gap(3); send(16'hC000); gap(2); send(16'h0000);

    // R6 R7: second edge in a word is dropped, flag sticks
    chk(multi_hit == 1'b0, "R7 flag clear before extra edge", multi_hit, 0);
    send(16'h8080); send(16'h0000);
    gap(2);
    chk(multi_hit == 1'b1, "R6 extra edge flagged", multi_hit, 1);
    send(16'hF00F); send(16'hFF00); send(16'h0000);  // ignored tail continues into next word
    gap(2);
    chk(multi_hit == 1'b1, "R7 flag sticky", multi_hit, 1);

    // R5: exactly the limit, then one beyond, then far beyond
    send(16'h0001); for (int i = 0; i < 15; i++) send(16'hFFFF); send(16'hFFFC); send(16'h0000);
    send(16'h0001); for (int i = 0; i < 15; i++) send(16'hFFFF); send(16'hFFFE); send(16'h0000);
    for (int i = 0; i < 20; i++) send(16'hFFFF); send(16'h0000);

    // R8: clear drops an open pulse and the same-cycle word, clears the flag
    send(16'h00FF); do_clr(16'h0F0F); send(16'h0000); gap(2);
    chk(multi_hit == 1'b0, "R8 clear resets flag", multi_hit, 0);
    chk(q_head == q_tail, "R8 no record for discarded pulse", q_tail - q_head, 0);

    // R10: count wraps; word index 64 reports coarse 0
    do_clr(16'h0000);
    for (int i = 0; i < 63; i++) send(16'h0000);
    send(16'h0100);
    send(16'h4000); send(16'h0000); gap(2);
    chk(last_time == 1, "R10 timestamp after wrap", last_time, 1);

    // near-exhaustive sweep: every word, interleaved with a scrambled partner
    do_clr(16'h0000);
    for (int k = 0; k < 65536; k++) begin
      send(W'(k));
      send(W'((k * 40503 + 7) & 16'hFFFF));
    end
    send(16'h0000); send(16'h0000); gap(3);
    chk(multi_hit == m_ovf[0], "R6 flag after sweep", multi_hit, m_ovf);
    chk(q_head == q_tail, "R4 all records delivered", q_tail - q_head, 0);
    chk(n_recs > 1000, "R3 sweep produced records", n_recs, 1000);
    finish_run();
  end
endmodule